// File: doc/BRIEF.md
# Serial EEPROM Byte Access Master

This block is a two-wire bus master dedicated to one serial EEPROM of 8192 bytes that uses a two-byte internal address. A client gives a single command: direction, a 13-bit start offset and a byte count. The block then runs the whole bus conversation by itself. Data to be written is taken one byte at a time from a data input. Read data comes back as a stream of valid pulses.

Writes go out as one bus transaction per byte. Each transaction is followed by address-only probes that repeat until the device answers again, which shows that its internal programming cycle has finished. A read first sets the device's address pointer with a write that carries no data and ends with a STOP. It then reads the whole count in one sequential burst.

Both lines are open drain. The block only ever pulls a line low through an output enable, and it samples the data line. A quarter-period divider on the system clock sets the bus clock rate. The default suits about 400 kHz from a 50 MHz clock.

Top module: `eeprom_i2c_ctrl`

## Requirements
- R1: Out of reset and whenever `busy` is low, neither line is pulled low (`scl_oe`=0, `sda_oe`=0), and `busy` and `done` are 0.
- R2: A command whose offset plus length exceeds 8192 finishes with `err`=1 and puts no START on the bus. A command ending exactly at byte 8192 is accepted.
- R3: A command with length 0 finishes with `err`=0 and no bus activity.
- R4: Every transaction begins with the device address byte: 0xA2 for writes and 0xA3 for reads (7-bit address 0x51, direction in bit 0, 1 = read). Offset bytes follow, high byte first. The high byte carries offset bits 12:8 with zeros above them.
- R5: Bytes are sent most significant bit first. SDA changes only while SCL is low, except during START and STOP.
- R6: A write of N bytes sends N separate transactions: address, offset high, offset low, one data byte, then STOP. Byte i lands at offset+i. `wr_take` pulses once per data byte, and the byte on `wr_data` is captured in the cycle before that pulse.
- R7: After each data STOP the block repeats START, 0xA2, STOP until the device acknowledges. Only then does it start the next byte.
- R8: If POLL_MAX probes in a row are not acknowledged, the command ends with `err`=3.
- R9: A missing acknowledge on a transaction's first address byte ends the command with a STOP and `err`=2. No data is taken or returned.
- R10: A read sends 0xA2 and both offset bytes, then STOP, then START and 0xA3. It then returns the requested bytes in address order, one `rd_valid` pulse each.
- R11: During a read the master acknowledges every received byte except the last one, which it leaves unacknowledged (SDA released).
- R12: SCL is high for 2·QDIV clock cycles in every data or acknowledge bit.
- R13: `busy` is high from the cycle after `req_start` until `done`. `done` is a one-cycle pulse. `err` holds 0 = ok, 1 = range, 2 = no acknowledge, 3 = timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Starts a command when idle |
| req_read | input | 1 | 1 = read, 0 = write |
| req_offset | input | 13 | First byte offset |
| req_len | input | LEN_W | Number of bytes |
| wr_data | input | 8 | Next byte to write |
| wr_take | output | 1 | Pulse: write byte consumed |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Pulse: `rd_data` valid |
| busy | output | 1 | Command in progress |
| done | output | 1 | Pulse: command finished |
| err | output | 2 | Result code of last command |
| sda_in | input | 1 | Sampled data line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
The in-line properties guard, on every cycle, the following:
- both lines are released whenever the block is idle;
- the data line stays stable while the clock is high, outside START and STOP;
- commands reach the bit engine only when it is free;
- `done` is a single-cycle pulse;
- take and valid pulses occur only during writes and reads respectively.

Only the bench scenarios, which use a behavioural EEPROM on the bus, can show the rest:
- the byte contents and their order;
- the number of probes made while the device is busy;
- where the final byte is left unacknowledged;
- the error codes for range, absent device and timeout;
- the measured SCL high time.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

    localparam int        MEM_BYTES = 8192;
    localparam int        OFF_W     = $clog2(MEM_BYTES);
    localparam logic [6:0] DEV_ADDR = 7'h51;

    typedef enum logic [1:0] {BC_START, BC_STOP, BC_WRITE, BC_READ} bus_cmd_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_RANGE   = 2'd1,
        ERR_NACK    = 2'd2,
        ERR_TIMEOUT = 2'd3
    } xfer_err_e;

    typedef enum logic [2:0] {ST_IDLE, ST_START, ST_TX, ST_RX, ST_STOP, ST_FIN} seq_st_e;

    typedef enum logic [2:0] {
        SP_ADDR_W, SP_OFF_HI, SP_OFF_LO, SP_DATA, SP_POLL, SP_ADDR_R
    } seq_step_e;

endpackage

// File: rtl/eeprom_i2c_tick.sv
module eeprom_i2c_tick #(
    parameter int QDIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == CW'(QDIV - 1));
        cnt_d = (!en || tick) ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/eeprom_i2c_phy.sv
module eeprom_i2c_phy
    import eeprom_i2c_pkg::*;
#(
    parameter int QDIV = 32
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_valid,
    input  bus_cmd_e cmd,
    input  logic     cmd_bit,
    output logic     done,
    output logic     rx_bit,
    input  logic     sda_in,
    output logic     scl_oe,
    output logic     sda_oe
);
    typedef struct packed {
        logic       busy;
        bus_cmd_e   cmd;
        logic       wbit;
        logic [1:0] ph;
        logic       scl;
        logic       sda;
        logic       rx;
        logic       done;
    } phy_s;

    phy_s d, q;
    logic tick;

    // {scl, sda} levels for each quarter of a bus symbol
    function automatic logic [1:0] lines_for(bus_cmd_e c, logic b, logic [1:0] p);
        case (c)
            BC_START: return (p == 2'd3) ? 2'b00 : ((p == 2'd2) ? 2'b10 : 2'b11);
            BC_STOP:  return (p == 2'd0) ? 2'b00 : ((p == 2'd3) ? 2'b11 : 2'b10);
            BC_WRITE: return {(p == 2'd1 || p == 2'd2), b};
            default:  return {(p == 2'd1 || p == 2'd2), 1'b1};
        endcase
    endfunction

    eeprom_i2c_tick #(.QDIV(QDIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (q.busy),
        .tick (tick)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (cmd_valid) begin
                d.busy        = 1'b1;
                d.cmd         = cmd;
                d.wbit        = cmd_bit;
                d.ph          = 2'd0;
                {d.scl, d.sda} = lines_for(cmd, cmd_bit, 2'd0);
            end
        end else if (tick) begin
            if (q.cmd == BC_READ && q.ph == 2'd2) d.rx = sda_in;
            if (q.ph == 2'd3) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.ph           = q.ph + 2'd1;
                {d.scl, d.sda} = lines_for(q.cmd, q.wbit, q.ph + 2'd1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.scl <= 1'b1;
            q.sda <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign done   = q.done;
    assign rx_bit = q.rx;
    assign scl_oe = !q.scl;
    assign sda_oe = !q.sda;

    // R5: data line only moves under a high clock during START or STOP
    a_r5_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (q.scl && $past(q.scl) && (q.sda != $past(q.sda))) |-> (q.cmd == BC_START || q.cmd == BC_STOP));

    // R13: sequencer hands over a symbol only when the engine is free
    a_r13_cmd_only_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !q.busy);
endmodule

// File: rtl/eeprom_i2c_ctrl.sv
module eeprom_i2c_ctrl
    import eeprom_i2c_pkg::*;
#(
    parameter int QDIV     = 32,
    parameter int POLL_MAX = 64,
    parameter int LEN_W    = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_start,
    input  logic             req_read,
    input  logic [12:0]      req_offset,
    input  logic [LEN_W-1:0] req_len,
    input  logic [7:0]       wr_data,
    output logic             wr_take,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             busy,
    output logic             done,
    output logic [1:0]       err,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe
);
    localparam int TW = $clog2(POLL_MAX + 1);
    localparam int SW = ((LEN_W > OFF_W) ? LEN_W : OFF_W) + 1;

    typedef struct packed {
        seq_st_e          st;
        seq_step_e        step;
        logic [3:0]       bitn;
        logic [7:0]       sh;
        logic [OFF_W-1:0] off;
        logic [LEN_W-1:0] left;
        logic [TW-1:0]    tries;
        logic             rd;
        logic             ack;
        logic             wait_ph;
        xfer_err_e        err;
        logic             done;
        logic [7:0]       rdat;
        logic             rvld;
        logic             wtk;
    } ctl_s;

    ctl_s     d, q;
    logic     phy_valid, phy_bit, phy_done, phy_rx;
    bus_cmd_e phy_cmd;
    logic [SW-1:0] span;

    function automatic logic [7:0] tx_byte(seq_step_e s, logic [OFF_W-1:0] o, logic [7:0] w);
        case (s)
            SP_OFF_HI: return 8'(o >> 8);
            SP_OFF_LO: return o[7:0];
            SP_DATA:   return w;
            SP_ADDR_R: return {DEV_ADDR, 1'b1};
            default:   return {DEV_ADDR, 1'b0};
        endcase
    endfunction

    eeprom_i2c_phy #(.QDIV(QDIV)) u_phy (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(phy_valid),
        .cmd      (phy_cmd),
        .cmd_bit  (phy_bit),
        .done     (phy_done),
        .rx_bit   (phy_rx),
        .sda_in   (sda_in),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.rvld = 1'b0;
        d.wtk  = 1'b0;
        span   = SW'(req_offset) + SW'(req_len);

        phy_valid = 1'b0;
        phy_cmd   = BC_START;
        phy_bit   = 1'b1;
        if (!q.wait_ph && (q.st inside {ST_START, ST_TX, ST_RX, ST_STOP})) begin
            phy_valid = 1'b1;
            d.wait_ph = 1'b1;
            case (q.st)
                ST_STOP: phy_cmd = BC_STOP;
                ST_TX: begin
                    phy_cmd = (q.bitn == 4'd8) ? BC_READ : BC_WRITE;
                    phy_bit = q.sh[7];
                end
                ST_RX: begin
                    phy_cmd = (q.bitn == 4'd8) ? BC_WRITE : BC_READ;
                    phy_bit = (q.bitn == 4'd8) ? (q.left == LEN_W'(1)) : 1'b1;
                end
                default: phy_cmd = BC_START;
            endcase
        end

        case (q.st)
            ST_IDLE: if (req_start) begin
                d.rd    = req_read;
                d.off   = req_offset;
                d.left  = req_len;
                d.err   = ERR_NONE;
                d.tries = '0;
                if (span > SW'(MEM_BYTES)) begin
                    d.err = ERR_RANGE;
                    d.st  = ST_FIN;
                end else if (req_len == '0) begin
                    d.st = ST_FIN;
                end else begin
                    d.step = SP_ADDR_W;
                    d.st   = ST_START;
                end
            end
            ST_FIN: begin
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
            default: if (q.wait_ph && phy_done) begin
                d.wait_ph = 1'b0;
                case (q.st)
                    ST_START: begin
                        d.st   = ST_TX;
                        d.bitn = '0;
                        d.sh   = tx_byte(q.step, q.off, wr_data);
                    end
                    ST_TX: if (q.bitn != 4'd8) begin
                        d.sh   = {q.sh[6:0], 1'b0};
                        d.bitn = q.bitn + 4'd1;
                    end else begin
                        d.ack  = !phy_rx;
                        d.bitn = '0;
                        case (q.step)
                            SP_ADDR_W: if (phy_rx) begin
                                d.err = ERR_NACK;
                                d.st  = ST_STOP;
                            end else begin
                                d.step = SP_OFF_HI;
                                d.sh   = tx_byte(SP_OFF_HI, q.off, wr_data);
                            end
                            SP_OFF_HI: begin
                                d.step = SP_OFF_LO;
                                d.sh   = tx_byte(SP_OFF_LO, q.off, wr_data);
                            end
                            SP_OFF_LO: if (q.rd) begin
                                d.st = ST_STOP;
                            end else begin
                                d.step = SP_DATA;
                                d.sh   = wr_data;
                                d.wtk  = 1'b1;
                            end
                            SP_ADDR_R: if (phy_rx) begin
                                d.err = ERR_NACK;
                                d.st  = ST_STOP;
                            end else begin
                                d.st = ST_RX;
                            end
                            default: d.st = ST_STOP;
                        endcase
                    end
                    ST_RX: if (q.bitn != 4'd8) begin
                        d.sh   = {q.sh[6:0], phy_rx};
                        d.bitn = q.bitn + 4'd1;
                        if (q.bitn == 4'd7) begin
                            d.rdat = {q.sh[6:0], phy_rx};
                            d.rvld = 1'b1;
                        end
                    end else begin
                        d.left = q.left - LEN_W'(1);
                        d.bitn = '0;
                        if (q.left == LEN_W'(1)) d.st = ST_STOP;
                    end
                    default: begin
                        d.st = ST_FIN;
                        if (q.err == ERR_NONE) begin
                            case (q.step)
                                SP_OFF_LO: begin
                                    d.step = SP_ADDR_R;
                                    d.st   = ST_START;
                                end
                                SP_DATA: begin
                                    d.step  = SP_POLL;
                                    d.tries = '0;
                                    d.st    = ST_START;
                                end
                                SP_POLL: if (q.ack) begin
                                    d.left = q.left - LEN_W'(1);
                                    d.off  = q.off + OFF_W'(1);
                                    if (q.left != LEN_W'(1)) begin
                                        d.step = SP_ADDR_W;
                                        d.st   = ST_START;
                                    end
                                end else if (q.tries == TW'(POLL_MAX - 1)) begin
                                    d.err = ERR_TIMEOUT;
                                end else begin
                                    d.tries = q.tries + TW'(1);
                                    d.st    = ST_START;
                                end
                                default: d.st = ST_FIN;
                            endcase
                        end
                    end
                endcase
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;
    assign err      = q.err;
    assign rd_data  = q.rdat;
    assign rd_valid = q.rvld;
    assign wr_take  = q.wtk;

    // R1: an idle block never pulls a line low
    a_r1_idle_lines_free: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    // R2: a rejected range never reaches the bus
    a_r2_range_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.err == ERR_RANGE) |-> (!scl_oe && !sda_oe));

    // R13: completion is a single-cycle pulse
    a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: bytes are consumed only by write commands
    a_r6_take_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |-> (busy && !q.rd));

    // R10: bytes are produced only by read commands
    a_r10_valid_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (busy && q.rd));
endmodule

// File: tb/eeprom_i2c_ctrl_tb.sv
module eeprom_i2c_ctrl_tb;
    localparam int QDIV = 4, POLL_MAX = 5, LEN_W = 14;

    logic clk = 1'b0, rst_n = 1'b0;
    always #10 clk = ~clk;

    logic req_start = 0, req_read = 0;
    logic [12:0] req_offset = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [7:0] wr_data = '0, rd_data;
    logic wr_take, rd_valid, busy, done, sda_in, scl_oe, sda_oe;
    logic [1:0] err;

    eeprom_i2c_ctrl #(.QDIV(QDIV), .POLL_MAX(POLL_MAX), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_read(req_read),
        .req_offset(req_offset), .req_len(req_len), .wr_data(wr_data), .wr_take(wr_take),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done), .err(err),
        .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe));

    // behavioural EEPROM on the bus
    logic m_drive = 0, scl_q = 1, sda_q = 1, m_rw = 0, m_wrote = 0, m_mack = 0, m_nack_all = 0;
    int m_phase = 0, m_bit = 0, m_ix = 0, m_busy = 0, m_busy_set = 0;
    logic [7:0] m_sh = '0;
    logic [12:0] m_ptr = '0;
    logic [7:0] mem [256];
    logic [7:0] rx_log [64];
    logic mack_log [16];
    int rx_n = 0, mack_n = 0, n_start = 0, n_poll_nak = 0, n_addr_nak = 0, hi_run = 0, last_hi = 0;

    wire scl = !scl_oe;
    wire sda = !(sda_oe || m_drive);
    assign sda_in = sda;

    initial begin
        forever begin
            @(negedge clk);
            if (scl) hi_run++;
            else if (scl_q) begin last_hi = hi_run; hi_run = 0; end
            if (scl && scl_q && sda_q && !sda) begin
                n_start++; m_phase = 1; m_bit = 0; m_ix = 0; m_wrote = 0; m_drive = 0;
            end else if (scl && scl_q && !sda_q && sda) begin
                if (m_wrote) m_busy = m_busy_set;
                m_phase = 0; m_drive = 0;
            end else if (scl && !scl_q) begin
                if (m_phase == 1) begin m_sh = {m_sh[6:0], sda}; m_bit++; end
                else if (m_phase == 4) m_mack = sda;
            end else if (!scl && scl_q) begin
                case (m_phase)
                    1: if (m_bit == 8) begin
                        rx_log[rx_n % 64] = m_sh; rx_n++;
                        if (m_ix == 0) begin
                            if (m_sh[7:1] == 7'h51 && !m_nack_all && m_busy == 0) begin
                                m_rw = m_sh[0]; m_drive = 1; m_phase = 2;
                            end else begin
                                if (m_busy > 0) begin m_busy--; n_poll_nak++; end
                                n_addr_nak++; m_phase = 0;
                            end
                        end else begin
                            if (m_ix == 1) m_ptr[12:8] = m_sh[4:0];
                            else if (m_ix == 2) m_ptr[7:0] = m_sh;
                            else begin mem[m_ptr[7:0]] = m_sh; m_ptr++; m_wrote = 1; end
                            m_drive = 1; m_phase = 2;
                        end
                        m_ix++;
                    end
                    2, 4: begin
                        if (m_phase == 4) begin mack_log[mack_n % 16] = m_mack; mack_n++; end
                        m_drive = 0;
                        if (m_phase == 4 && m_mack) m_phase = 0;
                        else if (m_rw) begin
                            m_sh = mem[m_ptr[7:0]]; m_ptr++;
                            m_drive = !m_sh[7]; m_bit = 1; m_phase = 3;
                        end else begin m_phase = 1; m_bit = 0; end
                    end
                    3: if (m_bit == 8) begin m_drive = 0; m_phase = 4; end
                       else begin m_drive = !m_sh[7 - m_bit]; m_bit++; end
                    default: ;
                endcase
            end
            scl_q = scl; sda_q = sda;
        end
    end

    int total = 0, bad = 0, takes = 0, rcnt = 0;
    logic [7:0] wbuf [4];
    logic [7:0] rbuf [8];
    logic [1:0] res;

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic run(logic rd, logic [12:0] off, int len);
        takes = 0; rcnt = 0; wr_data = wbuf[0];
        @(negedge clk);
        req_read = rd; req_offset = off; req_len = LEN_W'(len); req_start = 1;
        @(negedge clk);
        req_start = 0;
        chk("R13 busy after start", busy, 1);
        while (!done) begin
            if (wr_take) begin takes++; wr_data = wbuf[takes % 4]; end
            if (rd_valid) begin rbuf[rcnt % 8] = rd_data; rcnt++; end
            @(negedge clk);
        end
        res = err;
        @(negedge clk);
        chk("R13 done one cycle", done, 0);
        chk("R1 idle after done", {busy, scl_oe, sda_oe}, 0);
    endtask

    task automatic t_reset;
        chk("R1 reset scl", scl_oe, 0);
        chk("R1 reset sda", sda_oe, 0);
        chk("R1 reset busy/done", {busy, done}, 0);
    endtask

    task automatic t_range;
        int s0 = n_start;
        run(0, 13'd8190, 3);
        chk("R2 range err", res, 1);
        chk("R2 no start", n_start - s0, 0);
        run(1, 13'd100, 0);
        chk("R3 zero len err", res, 0);
        chk("R3 no start", n_start - s0, 0);
    endtask

    task automatic t_write;
        int b = rx_n, s0 = n_start, p0 = n_poll_nak;
        m_busy_set = 2; wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
        run(0, 13'd8190, 2);
        chk("R2 end at 8192 accepted", res, 0);
        chk("R6 takes", takes, 2);
        chk("R6 byte0", mem[8'hFE], 8'hA5);
        chk("R6 byte1", mem[8'hFF], 8'h3C);
        chk("R4 addr write", rx_log[b % 64], 8'hA2);
        chk("R4 off hi", rx_log[(b + 1) % 64], 8'h1F);
        chk("R4 off lo", rx_log[(b + 2) % 64], 8'hFE);
        chk("R5 msb first data", rx_log[(b + 3) % 64], 8'hA5);
        chk("R7 busy probes", n_poll_nak - p0, 4);
        chk("R7 starts", n_start - s0, 8);
        m_busy_set = 0;
    endtask

    task automatic t_read;
        int b = rx_n, s0 = n_start, k0 = mack_n;
        mem[8'h10] = 8'h11; mem[8'h11] = 8'h22; mem[8'h12] = 8'h33; mem[8'h13] = 8'h44;
        run(1, 13'h0010, 4);
        chk("R10 err", res, 0);
        chk("R10 count", rcnt, 4);
        for (int i = 0; i < 4; i++) chk("R10 data", rbuf[i], 8'h11 * (i + 1));
        chk("R10 dummy addr", rx_log[b % 64], 8'hA2);
        chk("R4 off hi zero", rx_log[(b + 1) % 64], 8'h00);
        chk("R10 off lo", rx_log[(b + 2) % 64], 8'h10);
        chk("R4 addr read", rx_log[(b + 3) % 64], 8'hA3);
        chk("R10 starts", n_start - s0, 2);
        for (int i = 0; i < 4; i++) chk("R11 master ack", mack_log[(k0 + i) % 16], (i == 3) ? 1 : 0);
        chk("R12 scl high", last_hi, 2 * QDIV);
    endtask

    task automatic t_single_read;
        int k0 = mack_n;
        run(1, 13'd8191, 1);
        chk("R10 readback", rbuf[0], 8'h3C);
        chk("R11 single nack", {mack_n - k0, 32'(mack_log[k0 % 16])}, {32'd1, 32'd1});
    endtask

    task automatic t_nack;
        m_nack_all = 1;
        run(0, 13'd5, 1);
        chk("R9 write err", res, 2);
        chk("R9 no take", takes, 0);
        run(1, 13'd5, 2);
        chk("R9 read err", res, 2);
        chk("R9 no data", rcnt, 0);
        m_nack_all = 0;
    endtask

    task automatic t_timeout;
        int p0 = n_poll_nak;
        m_busy_set = 1000; wbuf[0] = 8'h77;
        run(0, 13'h0020, 1);
        chk("R8 timeout err", res, 3);
        chk("R8 probe count", n_poll_nak - p0, POLL_MAX);
        m_busy_set = 0; m_busy = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_range();
        t_write();
        t_read();
        t_single_read();
        t_nack();
        t_timeout();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule